// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers eight one-cycle event pulses from the peripheral sources (two handshake lines on each of two ports, a shift register, and three timers) into a 12-bit flag register. It holds a matching set of enable bits and drives one active-high, push-pull interrupt line. The line is high while any latched flag has its enable set.

Software reaches the two registers through a chip select, a write strobe, a read strobe and a small register address. Flags are cleared by writing ones to them. The enable register is changed with a set/clear idiom: one control bit in the written word decides whether the other ones in that word set or clear their enables.

The enable register does not place every source at its flag bit position. The third timer sits one bit higher, above the control bit, so the block remaps between the two layouts on every write, every readback and in the interrupt decision.

Top module: `irq_flag_enable`

## Requirements
- R1: After reset (active high), every flag and every enable is 0 and `irq` is low. The flag register reads 0x000 and the enable register reads 0x080.
- R2: A pulse on `srcPulse[i]` sets flag bit i on the next clock edge. Bit 0 is the second handshake line of port A, bit 1 its first handshake line, bit 2 the shift register, bit 3 the second handshake line of port B, bit 4 its first handshake line, bit 5 timer 1 underflow, bit 6 timer 2 underflow and bit 7 timer 3 compare.
- R3: A selected write to the flag register (address `FLAG_ADDR`, default 13) clears each flag bit 0–7 that is written as 1. Flags written as 0 keep their value.
- R4: If a source pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R5: A selected write to the enable register (address `EN_ADDR`, default 14) with bit 7 = 1 sets each enable that is written as 1. All other enables keep their value.
- R6: A selected enable write with bit 7 = 0 clears each enable that is written as 1. All other enables keep their value.
- R7: In the enable register, sources 0–6 sit at bits 0–6 and the timer 3 compare enable sits at bit 8. Bit 7 always reads as 1.
- R8: Flag bit 11 and `irq` are both 1 exactly when some flag is set and the enable for that same source is set.
- R9: Flag bits 8–10 and enable bits 9–11 always read 0, and writing ones to them changes no state.
- R10: With `sel` low, writes change no state and `rdData` is 0. `rdData` is also 0 whenever `rdStb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high |
| wrStb | input | 1 | Register write strobe |
| rdStb | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register address |
| wrData | input | DATA_W (12) | Write data |
| srcPulse | input | NUM_SRC (8) | One-cycle set pulses, one per source, in flag bit order |
| rdData | output | DATA_W (12) | Read data, combinational, 0 when not reading |
| irq | output | 1 | Interrupt request, active high |

## Verification
Each source is pulsed on its own with all enables cleared. This shows that every pulse lands at its own flag position and that a flag without its enable never raises the interrupt. Timer 3 is then pulsed with only the bit-8 enable set, and again with only bits 0–6 set; the two runs separate a correct remap from one that reuses the flag position. Enable writes with the control bit at 1 and at 0, plus writes carrying reserved bits, tell set from clear from ignore. A pulse landing in the same cycle as a clearing write, both on the same flag and on a neighbouring flag, shows that the source wins without blocking the clear of the other bit.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

  typedef struct packed {
    logic wrFlag;
    logic wrEnable;
    logic rdFlag;
    logic rdEnable;
  } ctrlStrobes_t;

  // Position of a source's enable bit: sources at or above the control bit
  // move up by one so the control bit stays free.
  function automatic int enPos(input int src, input int ctrlBit);
    return (src < ctrlBit) ? src : src + 1;
  endfunction

  // Inverse map: source index held at an enable bit position, or -1.
  function automatic int srcOfPos(input int pos, input int ctrlBit, input int numSrc);
    int res;
    res = -1;
    for (int s = 0; s < numSrc; s++)
      if (enPos(s, ctrlBit) == pos) res = s;
    return res;
  endfunction

endpackage

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 13,
  parameter int EN_ADDR   = 14
) (
  input  logic              sel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] FlagA = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] EnA   = ADDR_W'(EN_ADDR);

  logic hitFlag;
  logic hitEn;

  always_comb begin
    hitFlag = sel && (addr == FlagA);
    hitEn   = sel && (addr == EnA);
    strb.wrFlag   = hitFlag && wrStb;
    strb.wrEnable = hitEn   && wrStb;
    strb.rdFlag   = hitFlag && rdStb;
    strb.rdEnable = hitEn   && rdStb;
  end

endmodule

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 12,
  parameter int CTRL_BIT = 7,
  parameter int SUM_BIT  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               irq,
  output logic [DATA_W-1:0]  rdData
);

  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] pending;
  logic [DATA_W-1:0]  flagView;
  logic [DATA_W-1:0]  enView;

  // One flag cell per source: a pulse wins over a same-cycle clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clrHit;
    assign clrHit = strb.wrFlag && wrData[i];
    always_ff @(posedge clk) begin
      if (rst)              flagQ[i] <= 1'b0;
      else if (srcPulse[i]) flagQ[i] <= 1'b1;
      else if (clrHit)      flagQ[i] <= 1'b0;
    end
  end

  // Enable update walks the enable layout and maps back to source order.
  always_comb begin
    enNext = enQ;
    if (strb.wrEnable) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (srcOfPos(j, CTRL_BIT, NUM_SRC) >= 0 && wrData[j])
          enNext[srcOfPos(j, CTRL_BIT, NUM_SRC)] = wrData[CTRL_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) enQ <= '0;
    else     enQ <= enNext;
  end

  assign pending = flagQ & enQ;
  assign irq     = |pending;

  always_comb begin
    flagView = '0;
    flagView[NUM_SRC-1:0] = flagQ;
    flagView[SUM_BIT] = irq;
  end

  always_comb begin
    enView = '0;
    for (int s = 0; s < NUM_SRC; s++)
      enView[enPos(s, CTRL_BIT)] = enQ[s];
    enView[CTRL_BIT] = 1'b1;
  end

  always_comb begin
    if (strb.rdFlag)        rdData = flagView;
    else if (strb.rdEnable) rdData = enView;
    else                    rdData = '0;
  end

endmodule

// File: rtl/irq_flag_enable.sv
`timescale 1ns/1ps
module irq_flag_enable
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 13,
  parameter int EN_ADDR   = 14,
  parameter int CTRL_BIT  = 7,
  parameter int SUM_BIT   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wrStb,
  input  logic               rdStb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  ctrlStrobes_t       strb;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;

  irqc_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_ctrl (
    .sel(sel), .wrStb(wrStb), .rdStb(rdStb), .addr(addr), .strb(strb)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CTRL_BIT(CTRL_BIT), .SUM_BIT(SUM_BIT)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .srcPulse(srcPulse),
    .flagQ(flagQ), .enQ(enQ), .irq(irq), .rdData(rdData)
  );

endmodule

// File: rtl/irq_flag_enable_chk.sv
`timescale 1ns/1ps
module irq_flag_enable_chk
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 12,
  parameter int SUM_BIT = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               sel,
  input logic               rdStb,
  input ctrlStrobes_t       strb,
  input logic [DATA_W-1:0]  wrData,
  input logic [NUM_SRC-1:0] srcPulse,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic               irq,
  input logic [DATA_W-1:0]  rdData
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (flagQ == '0 && enQ == '0 && !irq));

  p_src_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|srcPulse) |=> ((flagQ & $past(srcPulse)) == $past(srcPulse)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.wrFlag && srcPulse == '0) |=> ((flagQ & $past(wrData[NUM_SRC-1:0])) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!strb.wrFlag && srcPulse == '0) |=> $stable(flagQ));

  p_src_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.wrFlag && (|(srcPulse & wrData[NUM_SRC-1:0])))
      |=> ((flagQ & $past(srcPulse)) == $past(srcPulse)));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strb.wrEnable |=> $stable(enQ));

  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    (enQ == '0 || flagQ == '0) |-> !irq);

  p_sum_bit_r8: assert property (@(posedge clk) disable iff (rst)
    strb.rdFlag |-> (rdData[SUM_BIT] == irq));

  p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
    !(sel && rdStb) |-> (rdData == '0));

endmodule

bind irq_flag_enable irq_flag_enable_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SUM_BIT(SUM_BIT)
) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .rdStb(rdStb), .strb(strb),
  .wrData(wrData), .srcPulse(srcPulse), .flagQ(flagQ), .enQ(enQ),
  .irq(irq), .rdData(rdData)
);

// File: tb/sim_irq_flag_enable.sv
`timescale 1ns/1ps
module sim_irq_flag_enable;

  localparam logic [3:0] FA = 4'd13;
  localparam logic [3:0] EA = 4'd14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wrStb = 1'b0;
  logic        rdStb = 1'b0;
  logic [3:0]  addr = '0;
  logic [11:0] wrData = '0;
  logic [7:0]  srcPulse = '0;
  logic [11:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_flag_enable u0 (
    .clk(clk), .rst(rst), .sel(sel), .wrStb(wrStb), .rdStb(rdStb),
    .addr(addr), .wrData(wrData), .srcPulse(srcPulse),
    .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [11:0] d,
                          input logic [7:0] pulse = '0, input logic cs = 1'b1);
    @(negedge clk);
    sel = cs; wrStb = 1'b1; addr = a; wrData = d; srcPulse = pulse;
    @(negedge clk);
    sel = 1'b0; wrStb = 1'b0; wrData = '0; srcPulse = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [11:0] d,
                         input logic cs = 1'b1);
    @(negedge clk);
    sel = cs; rdStb = 1'b1; addr = a;
    #1 d = rdData;
    sel = 1'b0; rdStb = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    srcPulse = m;
    @(negedge clk);
    srcPulse = '0;
  endtask

  task automatic clearAll();
    regWrite(FA, 12'h0FF);
    regWrite(EA, 12'h17F);
  endtask

  task automatic tReset();
    logic [11:0] v;
    regRead(FA, v); chk("R1 flag after reset", v, 12'h000);
    regRead(EA, v); chk("R1/R7 enable after reset", v, 12'h080);
    chk("R1 irq after reset", {11'd0, irq}, 12'h000);
  endtask

  task automatic tEnableSetClear();
    logic [11:0] v;
    regWrite(EA, 12'h0FF);
    regRead(EA, v); chk("R5 set low enables", v, 12'h0FF);
    regWrite(EA, 12'h180);
    regRead(EA, v); chk("R5/R7 set timer3 enable at bit 8", v, 12'h1FF);
    regWrite(EA, 12'h005);
    regRead(EA, v); chk("R6 clear bits 0 and 2", v, 12'h1FA);
    regWrite(EA, 12'hE80);
    regRead(EA, v); chk("R9 reserved enable bits ignored", v, 12'h1FA);
    regWrite(EA, 12'hFFF, '0, 1'b0);
    regRead(EA, v); chk("R10 write without select ignored", v, 12'h1FA);
    regRead(EA, v, 1'b0); chk("R10 read without select is zero", v, 12'h000);
    clearAll();
  endtask

  task automatic tEachSource();
    logic [11:0] v;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      regRead(FA, v); chk("R2 source sets own flag", v, 12'(1 << i));
      chk("R8 no irq without enable", {11'd0, irq}, 12'h000);
      regWrite(FA, 12'(1 << i));
      regRead(FA, v); chk("R3 write one clears flag", v, 12'h000);
    end
  endtask

  task automatic tRemap();
    logic [11:0] v;
    regWrite(EA, 12'h180);
    pulse(8'h80);
    regRead(FA, v); chk("R8/R7 summary with timer3 enable", v, 12'h880);
    chk("R8 irq with timer3 enable", {11'd0, irq}, 12'h001);
    regWrite(EA, 12'h100);
    regWrite(EA, 12'h0FF);
    regRead(FA, v); chk("R7 low enables do not gate timer3", v, 12'h080);
    chk("R7 irq low with bit7-only pattern", {11'd0, irq}, 12'h000);
    pulse(8'h20);
    chk("R8 irq from timer1 with enable", {11'd0, irq}, 12'h001);
    regWrite(FA, 12'h020);
    chk("R8 irq drops after clear", {11'd0, irq}, 12'h000);
    clearAll();
  endtask

  task automatic tFlagWrites();
    logic [11:0] v;
    pulse(8'hFF);
    regWrite(FA, 12'h0F0);
    regRead(FA, v); chk("R3 partial clear keeps zero-written", v, 12'h00F);
    regWrite(FA, 12'hF00);
    regRead(FA, v); chk("R9 reserved flag writes ignored", v, 12'h00F);
    regWrite(FA, 12'h00C, 8'h08);
    regRead(FA, v); chk("R4 pulse beats clear, neighbour cleared", v, 12'h00B);
    regWrite(FA, 12'h0FF, '0, 1'b0);
    regRead(FA, v); chk("R10 flag write without select ignored", v, 12'h00B);
    @(negedge clk);
    sel = 1'b1; addr = FA; #1;
    chk("R10 no read strobe gives zero", rdData, 12'h000);
    sel = 1'b0;
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tEnableSetClear();
    tEachSource();
    tRemap();
    tFlagWrites();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule